// File: doc/BRIEF.md
# Attribute-Typed Control/Status Register Bank

This block is a bank of 32-bit control and status registers. Every bit of every register has a fixed access class, and the bank enforces that class on each write. The classes are: fixed (read-only or reserved), plain read/write, event bits that hardware sets and software clears by writing 1, write-once bits, and set-only bits that only a reset can clear. Write-once bits lock one byte lane at a time. A byte becomes fixed after the first write that enables its lane, and it stays fixed until the next link reset.

Software has two ways in. The first is a direct port covering a 4 KB window, addressed by DWORD index with byte enables; it only answers while a window-enable bit is set. The second is a small configuration window of three registers: a control register holding the window enable, a select register holding a DWORD index, and a data port that reads or writes the selected register under the same class rules. Per-register event inputs feed the event bits. The whole contents of the bank are driven out for the surrounding hardware. There are two active-low asynchronous resets. The link reset clears everything except the fields loaded only at power-good. The power-good reset clears everything. Read data is combinational, so it reflects the stored state in the same cycle as the access.

The register kind follows the index modulo 6:
- kind 0: all fixed, value 32'h5EED_0C01.
- kind 1: all read/write, default 0.
- kind 2: [15:0] event, [23:16] read/write, [31:24] reserved, default 8'hA5 in [31:24].
- kind 3: all write-once, default 0.
- kind 4: [7:0] set-only, [15:8] read/write cleared only by power-good reset, [31:16] reserved with value 16'h3C3C.
- kind 5: all read/write, default 32'h1234_5678.

Top module: `attr_csr_bank`

## Requirements
- R1: After power-good reset, each register holds its kind's default from the layout above, with the window disabled and the select register at 0.
- R2: A write to read/write bits updates exactly the byte lanes whose enable is 1; lane n covers bits [8n+7:8n].
- R3: Each write-once byte lane accepts the first write that enables it after link reset and ignores every later write to that lane; lanes not yet written stay writable.
- R4: Set-only bits become 1 when written with 1, keep their value when written with 0, and return to 0 only on link reset or power-good reset.
- R5: Event bits are set by a 1 on the matching event input bit; writing 1 clears the bit and writing 0 leaves it; if the event and a clearing write hit the same bit in one cycle, the bit ends set.
- R6: Read-only and reserved bits keep their value under any write.
- R7: Kind 4 bits [15:8] keep their value through a link reset and return to 0 on a power-good reset.
- R8: Configuration offset 0 bit 0 is the window enable; offset 1 bits [9:0] are the select index, where byte lane 0 loads [7:0] and lane 1 loads [9:8]; offset 2 reads and writes the selected register under R2 to R6; offset 3 reads 0.
- R9: The direct port addresses register mm_word_addr; while the window enable is 0, direct reads return 0 and direct writes are dropped.
- R10: Reads at indexes with no register (index at or above the register count) return 0, and writes there are dropped, through both paths.
- R11: When a data-port write and a direct write occur in the same cycle, the data-port write is performed and the direct write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_link_n | input | 1 | Link reset, active low, asynchronous |
| rst_pg_n | input | 1 | Power-good reset, active low, asynchronous |
| mm_sel | input | 1 | Direct port access strobe |
| mm_wr | input | 1 | Direct port write (1) or read (0) |
| mm_word_addr | input | 10 | DWORD index in the 4 KB window |
| mm_be | input | 4 | Direct write byte enables |
| mm_wdata | input | 32 | Direct write data |
| mm_rdata | output | 32 | Direct read data, combinational |
| cfg_sel | input | 1 | Configuration window access strobe |
| cfg_wr | input | 1 | Configuration write (1) or read (0) |
| cfg_addr | input | 2 | Configuration register: 0 control, 1 select, 2 data port |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| hw_evt | input | 192 | Event inputs, 32 per register, register i at [32i+31:32i] |
| reg_q | output | 192 | Bank contents, register i at [32i+31:32i] |

## Verification
The hardest state to reach from the ports is the one where several pieces of history interact. Write-once lanes are locked in some bytes and open in others. A power-good-only field holds a value across a link reset. An event bit sees its hardware set and its software clear in the same edge. The bench reaches each of these with directed sequences first: partial-lane writes to the write-once register, a link reset placed between writes, and an event pulse driven together with a clearing write. It then runs seeded random traffic on both ports at once, with sparse events and rare link resets, so that lock patterns and set-only bits pile up in combinations the directed part does not list. A bench model predicts every register after each cycle.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int DW = 32;
  localparam int NKIND = 6;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_SEL  = 2'd1;
  localparam logic [1:0] CFG_DATA = 2'd2;

  typedef enum logic [2:0] {
    AT_RO, AT_RW, AT_HS, AT_WO, AT_W1O, AT_RSV, AT_RWPG
  } attr_e;

  // Access class of bit b in a register of the given kind.
  function automatic attr_e bit_attr(input int kind, input int b);
    case (kind % NKIND)
      0: return AT_RO;
      1: return AT_RW;
      2: return (b < 16) ? AT_HS : ((b < 24) ? AT_RW : AT_RSV);
      3: return AT_WO;
      4: return (b < 8) ? AT_W1O : ((b < 16) ? AT_RWPG : AT_RSV);
      default: return AT_RW;
    endcase
  endfunction

  function automatic logic [DW-1:0] attr_mask(input int kind, input attr_e a);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++) m[b] = (bit_attr(kind, b) == a);
    return m;
  endfunction

  function automatic logic [DW-1:0] reset_val(input int kind);
    case (kind % NKIND)
      0: return 32'h5EED_0C01;
      2: return 32'hA500_0000;
      4: return 32'h3C3C_0000;
      5: return 32'h1234_5678;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/csr_dword.sv
module csr_dword
  import csr_bank_pkg::*;
#(
  parameter int KIND  = 1,
  parameter int NBYTE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_link_n,
  input  logic             rst_pg_n,
  input  logic             wr_en,
  input  logic [NBYTE-1:0] wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    hw_set,
  output logic [DW-1:0]    q
);

  localparam logic [DW-1:0] M_FIX  = attr_mask(KIND, AT_RO) | attr_mask(KIND, AT_RSV);
  localparam logic [DW-1:0] M_RW   = attr_mask(KIND, AT_RW);
  localparam logic [DW-1:0] M_PG   = attr_mask(KIND, AT_RWPG);
  localparam logic [DW-1:0] M_HS   = attr_mask(KIND, AT_HS);
  localparam logic [DW-1:0] M_WO   = attr_mask(KIND, AT_WO);
  localparam logic [DW-1:0] M_W1O  = attr_mask(KIND, AT_W1O);
  localparam logic [DW-1:0] M_LINK = ~M_PG;
  localparam logic [DW-1:0] RST    = reset_val(KIND);

  logic             rst_any_n;
  logic [DW-1:0]    link_q, pg_q, nxt;
  logic [NBYTE-1:0] lock_q, lock_nxt;
  logic [DW-1:0]    lane_m, lk_m, wmask, wo_m;
  logic             upd;

  assign rst_any_n = rst_link_n & rst_pg_n;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTE; gb++) begin : g_lane
      assign lane_m[gb*8 +: 8] = {8{wr_be[gb]}};
      assign lk_m[gb*8 +: 8]   = {8{lock_q[gb]}};
    end
  endgenerate

  assign q = (link_q & M_LINK) | (pg_q & M_PG);

  // Next state, one term per access class.
  always_comb begin
    wmask    = wr_en ? lane_m : '0;
    wo_m     = wmask & ~lk_m;
    nxt      = (M_FIX & q)
             | ((M_RW | M_PG) & ((wmask & wr_data) | (~wmask & q)))
             | (M_HS & (hw_set | (q & ~(wmask & wr_data))))
             | (M_WO & ((wo_m & wr_data) | (~wo_m & q)))
             | (M_W1O & (q | (wmask & wr_data)));
    upd      = wr_en | (|(hw_set & M_HS));
    lock_nxt = lock_q | wr_be;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      link_q <= RST & M_LINK;
      lock_q <= '0;
    end else begin
      if (upd)   link_q <= nxt & M_LINK;
      if (wr_en) lock_q <= lock_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_pg_n) begin
    if (!rst_pg_n) pg_q <= RST & M_PG;
    else if (upd)  pg_q <= nxt & M_PG;
  end

  // R3: a locked write-once lane does not move
  a_r3_lane_locked: assert property (@(posedge clk) disable iff (!rst_any_n)
    $past(rst_any_n) |-> (((q ^ $past(q)) & $past(lk_m) & M_WO) == '0));

  // R4: set-only bits never fall outside reset
  a_r4_no_fall: assert property (@(posedge clk) disable iff (!rst_any_n)
    $past(rst_any_n) |-> ((($past(q) & ~q) & M_W1O) == '0));

  // R5: an event seen on an edge is present after it
  a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_any_n)
    $past(rst_any_n) |-> (((~q) & $past(hw_set) & M_HS) == '0));

  // R6: fixed bits hold their reset value
  a_r6_fixed_bits: assert property (@(posedge clk) disable iff (!rst_any_n)
    ((q & M_FIX) == (RST & M_FIX)));

endmodule

// File: rtl/csr_cfg_window.sv
module csr_cfg_window
  import csr_bank_pkg::*;
#(
  parameter int SELW = 10,
  parameter int NREG = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sel,
  input  logic            cfg_wr,
  input  logic [1:0]      cfg_addr,
  input  logic [1:0]      cfg_be_lo,
  input  logic [SELW-1:0] cfg_wdata_lo,
  input  logic [DW-1:0]   sel_rdata,
  output logic            win_en,
  output logic [SELW-1:0] sel_idx,
  output logic            sel_valid,
  output logic            data_wr,
  output logic [DW-1:0]   cfg_rdata
);

  localparam logic [SELW-1:0] NREG_W = SELW'(NREG);

  logic            win_q, win_nxt, win_ld;
  logic [SELW-1:0] sel_q, sel_nxt;
  logic            sel_ld;

  assign win_ld  = cfg_sel && cfg_wr && (cfg_addr == CFG_CTRL) && cfg_be_lo[0];
  assign sel_ld  = cfg_sel && cfg_wr && (cfg_addr == CFG_SEL) && (|cfg_be_lo);
  assign data_wr = cfg_sel && cfg_wr && (cfg_addr == CFG_DATA);

  always_comb begin
    win_nxt = cfg_wdata_lo[0];
    for (int b = 0; b < SELW; b++) begin
      sel_nxt[b] = ((b < 8) ? cfg_be_lo[0] : cfg_be_lo[1]) ? cfg_wdata_lo[b] : sel_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (win_ld) win_q <= win_nxt;
      if (sel_ld) sel_q <= sel_nxt;
    end
  end

  assign win_en    = win_q;
  assign sel_idx   = sel_q;
  assign sel_valid = (sel_q < NREG_W);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) begin
      case (cfg_addr)
        CFG_CTRL: cfg_rdata = {{(DW-1){1'b0}}, win_q};
        CFG_SEL:  cfg_rdata = {{(DW-SELW){1'b0}}, sel_q};
        CFG_DATA: cfg_rdata = sel_valid ? sel_rdata : '0;
        default:  cfg_rdata = '0;
      endcase
    end
  end

  // R8: select index changes only on a select write
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ld |=> $stable(sel_q));

endmodule

// File: rtl/attr_csr_bank.sv
module attr_csr_bank
  import csr_bank_pkg::*;
#(
  parameter int NREG   = 6,
  parameter int WIN_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_link_n,
  input  logic                 rst_pg_n,
  input  logic                 mm_sel,
  input  logic                 mm_wr,
  input  logic [WIN_AW-3:0]    mm_word_addr,
  input  logic [DW/8-1:0]      mm_be,
  input  logic [DW-1:0]        mm_wdata,
  output logic [DW-1:0]        mm_rdata,
  input  logic                 cfg_sel,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_addr,
  input  logic [DW/8-1:0]      cfg_be,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  input  logic [NREG*DW-1:0]   hw_evt,
  output logic [NREG*DW-1:0]   reg_q
);

  localparam int              SELW   = WIN_AW - 2;
  localparam int              NBYTE  = DW / 8;
  localparam logic [SELW-1:0] NREG_W = SELW'(NREG);

  logic            rst_any_n;
  logic            win_en, sel_valid, data_wr;
  logic [SELW-1:0] sel_idx;
  logic            ind_hit, dir_hit, mm_valid;
  logic [NBYTE-1:0] w_be;
  logic [DW-1:0]   w_data, mm_rd, ind_rd;
  logic [NREG-1:0] wr_vec;
  logic [DW-1:0]   q_arr [NREG];

  assign rst_any_n = rst_link_n & rst_pg_n;

  csr_cfg_window #(.SELW(SELW), .NREG(NREG)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_any_n),
    .cfg_sel      (cfg_sel),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_be_lo    (cfg_be[1:0]),
    .cfg_wdata_lo (cfg_wdata[SELW-1:0]),
    .sel_rdata    (ind_rd),
    .win_en       (win_en),
    .sel_idx      (sel_idx),
    .sel_valid    (sel_valid),
    .data_wr      (data_wr),
    .cfg_rdata    (cfg_rdata)
  );

  // Write routing: the data port takes precedence over the direct port.
  assign mm_valid = mm_word_addr < NREG_W;
  assign ind_hit  = data_wr && sel_valid;
  assign dir_hit  = mm_sel && mm_wr && win_en && mm_valid;
  assign w_be     = ind_hit ? cfg_be    : mm_be;
  assign w_data   = ind_hit ? cfg_wdata : mm_wdata;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      assign wr_vec[gi] = ind_hit ? (sel_idx == SELW'(gi))
                                  : (dir_hit && (mm_word_addr == SELW'(gi)));
      csr_dword #(.KIND(gi), .NBYTE(NBYTE)) u_dw (
        .clk        (clk),
        .rst_link_n (rst_link_n),
        .rst_pg_n   (rst_pg_n),
        .wr_en      (wr_vec[gi]),
        .wr_be      (w_be),
        .wr_data    (w_data),
        .hw_set     (hw_evt[gi*DW +: DW]),
        .q          (q_arr[gi])
      );
      assign reg_q[gi*DW +: DW] = q_arr[gi];
    end
  endgenerate

  always_comb begin
    mm_rd  = '0;
    ind_rd = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mm_word_addr == SELW'(i)) mm_rd  = q_arr[i];
      if (sel_idx == SELW'(i))      ind_rd = q_arr[i];
    end
  end

  assign mm_rdata = (mm_sel && win_en) ? mm_rd : '0;

  // R11: at most one register written per cycle
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_any_n)
    $onehot0(wr_vec));

  // R10: unmapped direct reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_any_n)
    (mm_sel && !mm_valid) |-> (mm_rdata == '0));

endmodule

// File: tb/sim_attr_csr_bank.sv
module sim_attr_csr_bank;

  localparam int NREG = 6;
  localparam int DW   = 32;

  logic              clk;
  logic              rst_link_n, rst_pg_n;
  logic              mm_sel, mm_wr;
  logic [9:0]        mm_word_addr;
  logic [3:0]        mm_be;
  logic [31:0]       mm_wdata, mm_rdata;
  logic              cfg_sel, cfg_wr;
  logic [1:0]        cfg_addr;
  logic [3:0]        cfg_be;
  logic [31:0]       cfg_wdata, cfg_rdata;
  logic [NREG*DW-1:0] hw_evt, reg_q;

  attr_csr_bank #(.NREG(NREG), .WIN_AW(12)) u0 (
    .clk(clk), .rst_link_n(rst_link_n), .rst_pg_n(rst_pg_n),
    .mm_sel(mm_sel), .mm_wr(mm_wr), .mm_word_addr(mm_word_addr), .mm_be(mm_be),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hw_evt(hw_evt), .reg_q(reg_q)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_q  [NREG];
  logic [3:0]  m_lk [NREG];
  logic        m_win;
  logic [9:0]  m_sel;

  // 0 fixed, 1 read/write, 2 event, 3 write-once, 4 set-only
  function automatic int cls(input int k, input int b);
    case (k % 6)
      0: return 0;
      2: return (b < 16) ? 2 : ((b < 24) ? 1 : 0);
      3: return 3;
      4: return (b < 8) ? 4 : ((b < 16) ? 1 : 0);
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] def_of(input int k);
    case (k % 6)
      0: return 32'h5EED_0C01;
      2: return 32'hA500_0000;
      4: return 32'h3C3C_0000;
      5: return 32'h1234_5678;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pg_only(input int k);
    return ((k % 6) == 4) ? 32'h0000_FF00 : 32'h0;
  endfunction

  function automatic logic [31:0] next_of(input int k, input logic [31:0] old,
      input logic [3:0] lk, input logic we, input logic [3:0] be,
      input logic [31:0] wd, input logic [31:0] hw);
    logic [31:0] n;
    for (int b = 0; b < 32; b++) begin
      logic en;
      en = we && be[b/8];
      case (cls(k, b))
        0: n[b] = old[b];
        1: n[b] = en ? wd[b] : old[b];
        2: n[b] = hw[b] | (old[b] & !(en && wd[b]));
        3: n[b] = (en && !lk[b/8]) ? wd[b] : old[b];
        default: n[b] = old[b] | (en && wd[b]);
      endcase
    end
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input bit pg);
    for (int i = 0; i < NREG; i++) begin
      if (pg) m_q[i] = def_of(i);
      else    m_q[i] = (m_q[i] & pg_only(i)) | (def_of(i) & ~pg_only(i));
      m_lk[i] = 4'h0;
    end
    m_win = 1'b0;
    m_sel = '0;
  endtask

  task automatic do_reset(input bit pg);
    rst_link_n = 1'b0;
    if (pg) rst_pg_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_link_n = 1'b1;
    rst_pg_n   = 1'b1;
    model_reset(pg);
    @(negedge clk);
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, reg_q[i*DW +: DW], m_q[i]);
  endtask

  // One cycle of traffic: drive after a falling edge, check reads, update the model
  // at the rising edge, then check the bank at the following falling edge.
  task automatic step(input logic d_s, input logic d_w, input logic [9:0] d_a,
      input logic [3:0] d_be, input logic [31:0] d_wd,
      input logic c_s, input logic c_w, input logic [1:0] c_a,
      input logic [3:0] c_be, input logic [31:0] c_wd,
      input logic [NREG*DW-1:0] hw, input string tag);
    logic [31:0] e_mm, e_cfg;
    logic ind, dir;
    mm_sel = d_s; mm_wr = d_w; mm_word_addr = d_a; mm_be = d_be; mm_wdata = d_wd;
    cfg_sel = c_s; cfg_wr = c_w; cfg_addr = c_a; cfg_be = c_be; cfg_wdata = c_wd;
    hw_evt = hw;
    #1ns;
    e_mm = (d_s && m_win && d_a < NREG) ? m_q[d_a] : 32'h0;
    e_cfg = 32'h0;
    if (c_s) begin
      case (c_a)
        2'd0: e_cfg = {31'h0, m_win};
        2'd1: e_cfg = {22'h0, m_sel};
        2'd2: e_cfg = (m_sel < NREG) ? m_q[m_sel] : 32'h0;
        default: e_cfg = 32'h0;
      endcase
    end
    chk({tag, " direct read"}, mm_rdata, e_mm);
    chk({tag, " config read"}, cfg_rdata, e_cfg);
    @(posedge clk);
    ind = c_s && c_w && (c_a == 2'd2) && (m_sel < NREG);
    dir = d_s && d_w && m_win && (d_a < NREG);
    for (int i = 0; i < NREG; i++) begin
      logic we;
      we = ind ? (m_sel == 10'(i)) : (dir && d_a == 10'(i));
      m_q[i] = next_of(i, m_q[i], m_lk[i], we, ind ? c_be : d_be,
                       ind ? c_wd : d_wd, hw[i*DW +: DW]);
      if (we) m_lk[i] = m_lk[i] | (ind ? c_be : d_be);
    end
    if (c_s && c_w && c_a == 2'd0 && c_be[0]) m_win = c_wd[0];
    if (c_s && c_w && c_a == 2'd1) begin
      if (c_be[0]) m_sel[7:0] = c_wd[7:0];
      if (c_be[1]) m_sel[9:8] = c_wd[9:8];
    end
    @(negedge clk);
    mm_sel = 1'b0; cfg_sel = 1'b0; mm_wr = 1'b0; cfg_wr = 1'b0; hw_evt = '0;
    check_bank(tag);
  endtask

  task automatic dwr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] wd,
                     input string tag);
    step(1, 1, a, be, wd, 0, 0, 2'd0, 4'h0, 32'h0, '0, tag);
  endtask

  task automatic drd(input logic [9:0] a, input string tag);
    step(1, 0, a, 4'h0, 32'h0, 0, 0, 2'd0, 4'h0, 32'h0, '0, tag);
  endtask

  task automatic cwr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] wd,
                     input string tag);
    step(0, 0, 10'h0, 4'h0, 32'h0, 1, 1, a, be, wd, '0, tag);
  endtask

  task automatic crd(input logic [1:0] a, input string tag);
    step(0, 0, 10'h0, 4'h0, 32'h0, 1, 0, a, 4'h0, 32'h0, '0, tag);
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NREG*DW-1:0] hv;
    rst_link_n = 1'b0; rst_pg_n = 1'b0;
    mm_sel = 0; mm_wr = 0; mm_word_addr = '0; mm_be = '0; mm_wdata = '0;
    cfg_sel = 0; cfg_wr = 0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0; hw_evt = '0;
    for (int i = 0; i < NREG; i++) begin m_q[i] = 32'h0; m_lk[i] = 4'h0; end
    @(negedge clk);
    do_reset(1'b1);

    // R1: defaults after power-good reset
    for (int i = 0; i < NREG; i++) chk("R1 reset value", reg_q[i*DW +: DW], def_of(i));
    crd(2'd0, "R1 window off after reset");
    crd(2'd1, "R1 select zero after reset");

    // R9: window disabled
    drd(10'd0, "R9 read with window off");
    dwr(10'd1, 4'hF, 32'hDEAD_BEEF, "R9 write with window off");
    chk("R9 dropped write", reg_q[1*DW +: DW], 32'h0);

    // R8: enable window
    cwr(2'd0, 4'h1, 32'h1, "R8 enable window");
    drd(10'd0, "R1 identity via direct read");

    // R2: lane-selective write
    dwr(10'd1, 4'b0101, 32'hAABB_CCDD, "R2 lane write");
    chk("R2 lanes 0 and 2", reg_q[1*DW +: DW], 32'h00BB_00DD);

    // R3: per-lane write-once
    dwr(10'd3, 4'b0001, 32'h0000_0011, "R3 first lane 0");
    dwr(10'd3, 4'b0001, 32'h0000_0022, "R3 second lane 0");
    chk("R3 lane 0 locked", reg_q[3*DW +: DW], 32'h0000_0011);
    dwr(10'd3, 4'hF, 32'h4433_2299, "R3 full write");
    chk("R3 other lanes open", reg_q[3*DW +: DW], 32'h4433_2211);
    dwr(10'd3, 4'hF, 32'h0, "R3 all locked");
    chk("R3 all lanes locked", reg_q[3*DW +: DW], 32'h4433_2211);

    // R4, R6, R7 on kind 4
    dwr(10'd4, 4'h1, 32'h0000_00F0, "R4 set bits");
    dwr(10'd4, 4'h1, 32'h0000_000F, "R4 write zeros");
    chk("R4 sticky", reg_q[4*DW +: DW] & 32'hFF, 32'hFF);
    dwr(10'd4, 4'b1110, 32'hFFFF_5A00, "R6 reserved plus R7 field");
    chk("R6 reserved kept", reg_q[4*DW +: DW] & 32'hFFFF_0000, 32'h3C3C_0000);

    // R5: events
    hv = '0; hv[2*DW + 0] = 1'b1; hv[2*DW + 3] = 1'b1;
    step(0, 0, 10'h0, 4'h0, 32'h0, 0, 0, 2'd0, 4'h0, 32'h0, hv, "R5 event set");
    chk("R5 bits set", reg_q[2*DW +: DW] & 32'hFFFF, 32'h0009);
    dwr(10'd2, 4'h1, 32'h0000_0001, "R5 clear bit 0");
    dwr(10'd2, 4'h1, 32'h0000_0000, "R5 write zero");
    chk("R5 bit 3 kept", reg_q[2*DW +: DW] & 32'hFFFF, 32'h0008);
    hv = '0; hv[2*DW + 3] = 1'b1;
    step(1, 1, 10'd2, 4'h1, 32'h0000_0008, 0, 0, 2'd0, 4'h0, 32'h0, hv, "R5 set beats clear");
    chk("R5 set wins", reg_q[2*DW +: DW] & 32'hFFFF, 32'h0008);

    // R6: identity register
    dwr(10'd0, 4'hF, 32'hFFFF_FFFF, "R6 read-only write");

    // R8: indirect path
    cwr(2'd1, 4'h3, 32'h0000_0005, "R8 select 5");
    crd(2'd2, "R8 data port read");
    cwr(2'd2, 4'hF, 32'hCAFE_F00D, "R8 data port write");
    chk("R8 indirect write", reg_q[5*DW +: DW], 32'hCAFE_F00D);

    // R10: unmapped
    dwr(10'd200, 4'hF, 32'h1111_1111, "R10 direct unmapped write");
    drd(10'd200, "R10 direct unmapped read");
    cwr(2'd1, 4'h3, 32'h0000_012C, "R10 select unmapped");
    cwr(2'd2, 4'hF, 32'h2222_2222, "R10 data port unmapped");
    crd(2'd2, "R10 data port unmapped read");
    crd(2'd3, "R8 spare offset reads zero");

    // R11: both ports write together
    cwr(2'd1, 4'h3, 32'h0000_0005, "R11 select 5");
    step(1, 1, 10'd1, 4'hF, 32'h7777_7777, 1, 1, 2'd2, 4'hF, 32'h0BAD_CAFE, '0,
         "R11 simultaneous");
    chk("R11 direct dropped", reg_q[1*DW +: DW], 32'h00BB_00DD);
    chk("R11 indirect done", reg_q[5*DW +: DW], 32'h0BAD_CAFE);

    // R7 / R4 / R3 across link reset
    do_reset(1'b0);
    check_bank("R7 link reset");
    chk("R7 field survives", reg_q[4*DW +: DW] & 32'hFF00, 32'h5A00);
    chk("R4 cleared by link reset", reg_q[4*DW +: DW] & 32'hFF, 32'h0);
    cwr(2'd0, 4'h1, 32'h1, "R8 re-enable");
    dwr(10'd3, 4'h1, 32'h0000_0077, "R3 unlocked after reset");
    chk("R3 relock after reset", reg_q[3*DW +: DW] & 32'hFF, 32'h77);
    do_reset(1'b1);
    chk("R7 cleared by power-good", reg_q[4*DW +: DW] & 32'hFF00, 32'h0);

    // Seeded random traffic on both ports
    void'($urandom(32'd20240517));
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] da;
      logic [NREG*DW-1:0] hr;
      da = ($urandom % 5 == 0) ? 10'($urandom) : 10'($urandom % 8);
      for (int i = 0; i < NREG; i++) hr[i*DW +: DW] = $urandom & $urandom & $urandom;
      if ($urandom % 2 == 0) hr = '0;
      if ($urandom % 250 == 0) do_reset($urandom % 3 == 0);
      step(1'($urandom), 1'($urandom), da, 4'($urandom), $urandom,
           1'($urandom % 3 == 0), 1'($urandom), 2'($urandom), 4'($urandom),
           ($urandom % 4 == 0) ? $urandom : ($urandom % 8), hr, "R2-model random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule